// File: doc/BRIEF.md
# Floating-Point Coprocessor Control/Status Register Unit

This block holds the three housekeeping registers of a stack-based floating-point coprocessor: the 16-bit control word, the 16-bit status word and the 16-bit tag word. It also executes the coprocessor's bookkeeping commands. These are: initialise, clear exceptions, load control word, store control word, store status word, move the top-of-stack pointer up or down, and free a register.

A command is given by a one-cycle strobe with a 3-bit opcode, a 3-bit register index and a 16-bit write value. The opcode encoding is: 0 initialise, 1 clear exceptions, 2 load control, 3 store control, 4 store status, 5 increment top, 6 decrement top, 7 free register.

The arithmetic core has side inputs to:
- raise exception flags, the stack-fault bit and the busy bit;
- write the four condition-code bits;
- write a single register tag.

The status word and the tag word are always visible on their own output ports. The interrupt request is high whenever a raised exception flag is not masked by the control word.

Top module: `fpu_ctrl_regs`

## Requirements
- R1: After reset, the status word is 0x0000, the tag word is 0xFFFF, the interrupt request is low, and a store-control command returns 0x037F.
- R2: Initialise (op 0) clears the status word to 0x0000, sets the tag word to 0xFFFF (all eight registers empty), reloads the control word with 0x037F and drops the interrupt request.
- R3: Clear exceptions (op 1) zeroes flag bits 5:0, stack fault bit 6 and busy bit 15. The top field and the condition bits are kept.
- R4: Increment (op 5) and decrement (op 6) move the top field in status bits 13:11 up or down by one, modulo 8.
- R5: Increment and decrement clear C1 (status bit 9) and keep C0 (bit 8), C2 (bit 10) and C3 (bit 14).
- R6: Free register (op 7) sets tag bits 2i+1:2i of register i = index to 2'b11 (empty). Every other tag is left unchanged.
- R7: Load control (op 2) stores the write value. Store control (op 3) presents the control word on the read port one cycle after the command.
- R8: Store status (op 4) presents the status word on the read port one cycle after the command. The status port shows the same word at all times.
- R9: The interrupt request equals the OR, over bits 5:0, of a set flag whose control mask bit is 0. Status bit 7 mirrors it. A load control that unmasks a pending flag raises the request in the very next cycle.
- R10: The flag, stack-fault and busy set inputs OR into the status word one cycle later. When one of them arrives in the same cycle as a command that would clear the bit, the bit still ends set.
- R11: A condition write loads C0 to C2 into status bits 10:8 from inputs 2:0, and C3 into bit 14 from input 3.
- R12: A tag write loads the 2-bit value into the tags of the selected register. A free or initialise in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | 3 | Register index for free |
| cmd_wdata | input | 16 | Value for load control |
| cmd_rdata | output | 16 | Result of store control / store status |
| exc_set | input | 6 | Exception flags raised by the core |
| sf_set | input | 1 | Stack fault raised by the core |
| busy_set | input | 1 | Busy raised by the core |
| cond_wr | input | 1 | Condition-code write strobe |
| cond_in | input | 4 | Condition codes {C3,C2,C1,C0} |
| tag_wr | input | 1 | Tag write strobe |
| tag_wr_idx | input | 3 | Register whose tag is written |
| tag_wr_val | input | 2 | Tag value written |
| status_out | output | 16 | Current status word |
| tag_out | output | 16 | Current tag word |
| irq_req | output | 1 | Unmasked-exception interrupt request |

## Verification
The hardest case to reach is the interrupt that fires from a control load rather than from a new exception. Reaching it needs a flag that is already pending while masked, followed by a control value that unmasks exactly that flag.

The bench sweeps all six flags:
- it raises each flag under the all-masked reset control word;
- it then loads a control word that clears only that flag's mask, and checks that the request is up one cycle later;
- it then loads the inverse pattern, which unmasks every other flag, and checks that the request stays low.

The top-field wrap in both directions and every index of the free command are also swept exhaustively.

// File: rtl/fcr_pkg.sv
`timescale 1ns/1ps
package fcr_pkg;
   typedef enum logic [2:0] {
      OP_INIT  = 3'd0,
      OP_CLEX  = 3'd1,
      OP_LDCW  = 3'd2,
      OP_STCW  = 3'd3,
      OP_STSW  = 3'd4,
      OP_INCT  = 3'd5,
      OP_DECT  = 3'd6,
      OP_FREE  = 3'd7
   } fcr_op_e;

   localparam int unsigned WORD_W = 16;
   localparam logic [1:0]  TAG_EMPTY = 2'b11;
endpackage

// File: rtl/fcr_ctrl_word.sv
`timescale 1ns/1ps
module fcr_ctrl_word #(
   parameter int unsigned W       = 16,
   parameter logic [W-1:0] INIT_CW = 16'h037F
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         do_init,
   input  logic         do_load,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] ctrl_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= INIT_CW;
      else if (do_init) ctrl_q <= INIT_CW;
      else if (do_load) ctrl_q <= wr_data;
   end
endmodule

// File: rtl/fcr_status_word.sv
`timescale 1ns/1ps
module fcr_status_word #(
   parameter int unsigned EXC_N = 6,
   parameter int unsigned TOP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_init,
   input  logic             do_clex,
   input  logic             do_inc,
   input  logic             do_dec,
   input  logic [EXC_N-1:0] exc_set,
   input  logic             sf_set,
   input  logic             busy_set,
   input  logic             cond_wr,
   input  logic [3:0]       cond_in,
   input  logic             err_sum,
   output logic [EXC_N-1:0] flags,
   output logic [15:0]      status_word
);
   logic [EXC_N-1:0] flags_n;
   logic             sf_q, sf_n, busy_q, busy_n;
   logic [3:0]       cc_q, cc_n;
   logic [TOP_W-1:0] top_q, top_n;

   always_comb begin
      flags_n = flags;
      sf_n    = sf_q;
      busy_n  = busy_q;
      top_n   = top_q;
      cc_n    = cond_wr ? cond_in : cc_q;
      if (do_init) begin
         flags_n = '0;
         sf_n    = 1'b0;
         busy_n  = 1'b0;
         top_n   = '0;
         cc_n    = '0;
      end else if (do_clex) begin
         flags_n = '0;
         sf_n    = 1'b0;
         busy_n  = 1'b0;
      end else if (do_inc) begin
         top_n   = top_q + 1'b1;
         cc_n[1] = 1'b0;
      end else if (do_dec) begin
         top_n   = top_q - 1'b1;
         cc_n[1] = 1'b0;
      end
      flags_n = flags_n | exc_set;
      sf_n    = sf_n | sf_set;
      busy_n  = busy_n | busy_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags  <= '0;
         sf_q   <= 1'b0;
         busy_q <= 1'b0;
         top_q  <= '0;
         cc_q   <= '0;
      end else begin
         flags  <= flags_n;
         sf_q   <= sf_n;
         busy_q <= busy_n;
         top_q  <= top_n;
         cc_q   <= cc_n;
      end
   end

   assign status_word = {busy_q, cc_q[3], top_q, cc_q[2:0], err_sum, sf_q, flags};
endmodule

// File: rtl/fcr_tag_word.sv
`timescale 1ns/1ps
module fcr_tag_word #(
   parameter int unsigned NREG  = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_init,
   input  logic              do_free,
   input  logic [IDX_W-1:0]  free_idx,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_val,
   output logic [2*NREG-1:0] tag_word
);
   import fcr_pkg::*;

   for (genvar g = 0; g < NREG; g++) begin : g_tag
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
      logic [1:0] tag_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            tag_q <= TAG_EMPTY;
         else if (do_init || (do_free && free_idx == MY_IDX))
            tag_q <= TAG_EMPTY;
         else if (wr_en && wr_idx == MY_IDX)
            tag_q <= wr_val;
      end
      assign tag_word[2*g +: 2] = tag_q;
   end
endmodule

// File: rtl/fpu_ctrl_regs.sv
`timescale 1ns/1ps
module fpu_ctrl_regs #(
   parameter int unsigned NREG    = 8,
   parameter int unsigned EXC_N   = 6,
   parameter logic [15:0] INIT_CW = 16'h037F
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [2:0]  cmd_op,
   input  logic [2:0]  cmd_idx,
   input  logic [15:0] cmd_wdata,
   output logic [15:0] cmd_rdata,
   input  logic [5:0]  exc_set,
   input  logic        sf_set,
   input  logic        busy_set,
   input  logic        cond_wr,
   input  logic [3:0]  cond_in,
   input  logic        tag_wr,
   input  logic [2:0]  tag_wr_idx,
   input  logic [1:0]  tag_wr_val,
   output logic [15:0] status_out,
   output logic [15:0] tag_out,
   output logic        irq_req
);
   import fcr_pkg::*;

   localparam int unsigned IDX_W = $clog2(NREG);
   localparam int unsigned TAG_W = 2 * NREG;

   if (TAG_W != WORD_W) begin : g_bad_nreg
      $error("NREG must give a tag word of exactly WORD_W bits");
   end
   if (IDX_W != 3) begin : g_bad_top
      $error("top field of the status word is fixed at 3 bits");
   end
   if (EXC_N != 6) begin : g_bad_exc
      $error("status word holds exactly six exception flags");
   end

   fcr_op_e          op;
   logic             do_init, do_clex, do_ldcw, do_stcw, do_stsw;
   logic             do_inc, do_dec, do_free;
   logic [15:0]      ctrl_word;
   logic [EXC_N-1:0] flags;
   logic             err_sum;

   assign op      = fcr_op_e'(cmd_op);
   assign do_init = cmd_valid && op == OP_INIT;
   assign do_clex = cmd_valid && op == OP_CLEX;
   assign do_ldcw = cmd_valid && op == OP_LDCW;
   assign do_stcw = cmd_valid && op == OP_STCW;
   assign do_stsw = cmd_valid && op == OP_STSW;
   assign do_inc  = cmd_valid && op == OP_INCT;
   assign do_dec  = cmd_valid && op == OP_DECT;
   assign do_free = cmd_valid && op == OP_FREE;

   fcr_ctrl_word #(.W(WORD_W), .INIT_CW(INIT_CW)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_init (do_init),
      .do_load (do_ldcw),
      .wr_data (cmd_wdata),
      .ctrl_q  (ctrl_word)
   );

   assign err_sum = |(flags & ~ctrl_word[EXC_N-1:0]);
   assign irq_req = err_sum;

   fcr_status_word #(.EXC_N(EXC_N), .TOP_W(IDX_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .do_init     (do_init),
      .do_clex     (do_clex),
      .do_inc      (do_inc),
      .do_dec      (do_dec),
      .exc_set     (exc_set),
      .sf_set      (sf_set),
      .busy_set    (busy_set),
      .cond_wr     (cond_wr),
      .cond_in     (cond_in),
      .err_sum     (err_sum),
      .flags       (flags),
      .status_word (status_out)
   );

   fcr_tag_word #(.NREG(NREG), .IDX_W(IDX_W)) u_tag (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_init  (do_init),
      .do_free  (do_free),
      .free_idx (cmd_idx),
      .wr_en    (tag_wr),
      .wr_idx   (tag_wr_idx),
      .wr_val   (tag_wr_val),
      .tag_word (tag_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       cmd_rdata <= '0;
      else if (do_stcw) cmd_rdata <= ctrl_word;
      else if (do_stsw) cmd_rdata <= status_out;
   end
endmodule

// File: rtl/fpu_ctrl_regs_chk.sv
`timescale 1ns/1ps
module fpu_ctrl_regs_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic [2:0]  cmd_op,
   input logic [2:0]  cmd_idx,
   input logic [5:0]  exc_set,
   input logic        sf_set,
   input logic        busy_set,
   input logic        cond_wr,
   input logic [15:0] status_out,
   input logic [15:0] tag_out,
   input logic        irq_req,
   input logic [15:0] cmd_rdata,
   input logic [15:0] ctrl_word
);
   p_es_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status_out[7] == irq_req);

   p_irq_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == |(status_out[5:0] & ~ctrl_word[5:0]));

   p_top_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd5) |=> status_out[13:11] == $past(status_out[13:11]) + 3'd1);

   p_top_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd6) |=> status_out[13:11] == $past(status_out[13:11]) - 3'd1);

   p_c1_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'd5 || cmd_op == 3'd6) && !cond_wr) |=> !status_out[9]);

   p_free_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd7) |=> tag_out[{$past(cmd_idx), 1'b0} +: 2] == 2'b11);

   p_init_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd0 && exc_set == 6'd0 && !sf_set && !busy_set)
      |=> (status_out == 16'h0000 && tag_out == 16'hFFFF && !irq_req));

   p_clex_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && exc_set == 6'd0 && !sf_set && !busy_set)
      |=> (status_out[6:0] == 7'd0 && !status_out[15]));

   p_stcw_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd3) |=> cmd_rdata == $past(ctrl_word));
endmodule

bind fpu_ctrl_regs fpu_ctrl_regs_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .cmd_idx    (cmd_idx),
   .exc_set    (exc_set),
   .sf_set     (sf_set),
   .busy_set   (busy_set),
   .cond_wr    (cond_wr),
   .status_out (status_out),
   .tag_out    (tag_out),
   .irq_req    (irq_req),
   .cmd_rdata  (cmd_rdata),
   .ctrl_word  (ctrl_word)
);

// File: tb/tb_fpu_ctrl_regs.sv
`timescale 1ns/1ps
module tb_fpu_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [2:0]  cmd_idx = '0;
   logic [15:0] cmd_wdata = '0;
   logic [15:0] cmd_rdata;
   logic [5:0]  exc_set = '0;
   logic        sf_set = 1'b0;
   logic        busy_set = 1'b0;
   logic        cond_wr = 1'b0;
   logic [3:0]  cond_in = '0;
   logic        tag_wr = 1'b0;
   logic [2:0]  tag_wr_idx = '0;
   logic [1:0]  tag_wr_val = '0;
   logic [15:0] status_out;
   logic [15:0] tag_out;
   logic        irq_req;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fpu_ctrl_regs dut (.*);

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [2:0] idx, input logic [15:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic raise(input logic [5:0] f, input logic sf, input logic bz);
      @(negedge clk);
      exc_set = f; sf_set = sf; busy_set = bz;
      @(negedge clk);
      exc_set = '0; sf_set = 1'b0; busy_set = 1'b0;
   endtask

   task automatic cond(input logic [3:0] c);
      @(negedge clk);
      cond_wr = 1'b1; cond_in = c;
      @(negedge clk);
      cond_wr = 1'b0;
   endtask

   task automatic twr(input logic [2:0] i, input logic [1:0] v);
      @(negedge clk);
      tag_wr = 1'b1; tag_wr_idx = i; tag_wr_val = v;
      @(negedge clk);
      tag_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0] top;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status_out, 16'h0000);
      chk("R1 tags", tag_out, 16'hFFFF);
      chk("R1 irq", {15'd0, irq_req}, 16'd0);
      issue(3'd3, 3'd0, 16'h0);
      chk("R1 ctrl", cmd_rdata, 16'h037F);

      // R11 condition write
      cond(4'b1111);
      chk("R11 cond all", status_out, 16'h4700);
      cond(4'b0101);
      chk("R11 cond mix", status_out, 16'h0500);

      // R4 R5 top sweep up then down
      top = 3'd0;
      for (int k = 0; k < 8; k++) begin
         cond(4'b1111);
         issue(3'd5, 3'd0, 16'h0);
         top = top + 3'd1;
         chk("R4 R5 inc", status_out, 16'h4500 | (16'(top) << 11));
      end
      for (int k = 0; k < 9; k++) begin
         cond(4'b1111);
         issue(3'd6, 3'd0, 16'h0);
         top = top - 3'd1;
         chk("R4 R5 dec", status_out, 16'h4500 | (16'(top) << 11));
      end

      // R10 set inputs and R3 clear exceptions (all masked)
      issue(3'd0, 3'd0, 16'h0);
      issue(3'd5, 3'd0, 16'h0);
      cond(4'b1101);
      for (int j = 0; j < 6; j++) begin
         raise(6'(1 << j), 1'b0, 1'b0);
         chk("R10 flag", status_out, 16'h4D00 | 16'(1 << j));
         chk("R9 masked irq", {15'd0, irq_req}, 16'd0);
         issue(3'd1, 3'd0, 16'h0);
         chk("R3 clex flag", status_out, 16'h4D00);
      end
      raise(6'h3F, 1'b1, 1'b1);
      chk("R10 all set", status_out, 16'hCD7F);
      issue(3'd4, 3'd0, 16'h0);
      chk("R8 stsw", cmd_rdata, 16'hCD7F);
      issue(3'd1, 3'd0, 16'h0);
      chk("R3 clex all", status_out, 16'h4D00);

      // R10 set arriving with clear
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd1; exc_set = 6'h08;
      @(negedge clk);
      cmd_valid = 1'b0; exc_set = '0;
      chk("R10 set beats clex", status_out, 16'h4D08);

      // R9 unmask pending flag
      for (int j = 0; j < 6; j++) begin
         issue(3'd0, 3'd0, 16'h0);
         raise(6'(1 << j), 1'b0, 1'b0);
         chk("R9 pending masked", {15'd0, irq_req}, 16'd0);
         issue(3'd2, 3'd0, 16'h037F & ~16'(1 << j));
         chk("R9 irq raised", {15'd0, irq_req}, 16'd1);
         chk("R9 es bit", status_out, 16'h0080 | 16'(1 << j));
         issue(3'd2, 3'd0, 16'h0340 | 16'(1 << j));
         chk("R9 others unmasked", {15'd0, irq_req}, 16'd0);
         issue(3'd2, 3'd0, 16'h0300);
         issue(3'd1, 3'd0, 16'h0);
         chk("R9 cleared", {15'd0, irq_req}, 16'd0);
      end

      // R7 load / store control
      for (int v = 0; v < 4; v++) begin
         logic [15:0] val;
         val = 16'h1234 ^ 16'(v * 16'h2F1B);
         issue(3'd2, 3'd0, val);
         issue(3'd3, 3'd0, 16'h0);
         chk("R7 stcw", cmd_rdata, val);
      end

      // R12 tag write, R6 free every index
      for (int i = 0; i < 8; i++) begin
         for (int r = 0; r < 8; r++) twr(3'(r), 2'(r));
         chk("R12 tag write", tag_out, 16'hE4E4);
         issue(3'd7, 3'(i), 16'h0);
         chk("R6 free", tag_out, 16'hE4E4 | (16'h3 << (2 * i)));
      end
      // R12 free beats write on same register
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd7; cmd_idx = 3'd2;
      tag_wr = 1'b1; tag_wr_idx = 3'd2; tag_wr_val = 2'b00;
      @(negedge clk);
      cmd_valid = 1'b0; tag_wr = 1'b0;
      chk("R12 free priority", tag_out[5:4], 16'h3);

      // R2 initialise from busy state
      cond(4'b1111);
      raise(6'h21, 1'b1, 1'b1);
      issue(3'd2, 3'd0, 16'h0000);
      chk("R2 pre irq", {15'd0, irq_req}, 16'd1);
      issue(3'd0, 3'd0, 16'h0);
      chk("R2 status", status_out, 16'h0000);
      chk("R2 tags", tag_out, 16'hFFFF);
      chk("R2 irq", {15'd0, irq_req}, 16'd0);
      issue(3'd3, 3'd0, 16'h0);
      chk("R2 ctrl", cmd_rdata, 16'h037F);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule